// File: doc/BRIEF.md
# Dual-Read Register File

This block is the general-purpose register storage of a simple load/store processor datapath. It holds thirty-two 32-bit words. Two read ports return stored words without any clock, so the operand fetch of a pipeline stage can settle within the same cycle. One write port stores a word on the falling clock edge when its enable is high. Because the write uses the falling edge, a write-back in the first half of a cycle is visible to reads in the second half.

Slot zero is a hard-wired constant. A write that targets it is dropped, and both ports return zero for it. An active-high clear input, which does not wait for the clock, empties the whole bank and overrides any write.

Top module: `regbank`

## Requirements
- R1: The bank has 32 independent 32-bit slots, addressed by 5-bit indices. A value written to one nonzero slot leaves every other slot unchanged.
- R2: Each read port drives the word stored at its index combinationally. A change of the read index alone changes the read data with no clock edge.
- R3: When `wr_en` is 1 at a falling edge of `clk`, `wr_data` is stored into slot `wr_idx`.
- R4: Reading index 0 on either port returns 0 at all times, including after a write with `wr_idx` = 0.
- R5: While `clr` is 1, every slot reads 0, with or without a clock edge. A write attempted while `clr` is 1 is lost.
- R6: When both read ports select the same index, they return the same full 32-bit word.
- R7: A slot being written shows its old value until the falling edge and the new value after it.
- R8: When `wr_en` is 0 at a falling edge, no slot changes, whatever `wr_idx` and `wr_data` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on its falling edge |
| clr | input | 1 | Asynchronous active-high clear of all slots |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Slot index for the write |
| wr_data | input | 32 | Word to write |
| rd_a_idx | input | 5 | Slot index for read port A |
| rd_a_data | output | 32 | Word read on port A |
| rd_b_idx | input | 5 | Slot index for read port B |
| rd_b_data | output | 32 | Word read on port B |

## Verification
The bench builds the block with its default values: 32 slots and 32-bit words. With this size the bench can fill every slot and read each one back on both ports, so index aliasing between slots is in reach. The 32-bit width lets it use patterns that set the top bit and the bottom bit, which shows any truncated lane. The bench also drives the clear between clock edges and with the write enable high, which covers the asynchronous path and the case where the clear overrides a write.

// File: rtl/regbank.sv
module regbank #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data
);

  logic [DATA_W-1:0] slots [NUM_REGS];

  always_ff @(negedge clk or posedge clr) begin
    if (clr) begin
      for (int i = 0; i < NUM_REGS; i++) slots[i] <= '0;
    end else if (wr_en && (wr_idx != '0)) begin
      slots[wr_idx] <= wr_data;
    end
  end

  assign rd_a_data = (rd_a_idx == '0) ? '0 : slots[rd_a_idx];
  assign rd_b_data = (rd_b_idx == '0) ? '0 : slots[rd_b_idx];

endmodule

module regbank_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              clr,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [IDX_W-1:0]  rd_b_idx,
  input logic [DATA_W-1:0] rd_b_data
);

  AST_ZERO_PORT_A: assert property (@(negedge clk) disable iff (clr)
    (rd_a_idx == '0) |-> (rd_a_data == '0)); // R4
  AST_ZERO_PORT_B: assert property (@(negedge clk) disable iff (clr)
    (rd_b_idx == '0) |-> (rd_b_data == '0)); // R4
  AST_SAME_INDEX_MATCH: assert property (@(negedge clk) disable iff (clr)
    (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data)); // R6
  AST_WRITE_LANDS: assert property (@(negedge clk) disable iff (clr)
    (wr_en && wr_idx != '0) ##1 (rd_a_idx == $past(wr_idx)) |-> (rd_a_data == $past(wr_data))); // R3
  AST_IDLE_HOLDS: assert property (@(negedge clk) disable iff (clr)
    (!wr_en) ##1 $stable(rd_a_idx) |-> $stable(rd_a_data)); // R8

  always @(posedge clk) begin
    if (clr) begin
      AST_CLEAR_EMPTY: assert (rd_a_data == '0 && rd_b_data == '0); // R5
    end
  end

endmodule

bind regbank regbank_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/regbank_bench.sv
module regbank_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        clr = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_a_idx = '0;
  logic [31:0] rd_a_data;
  logic [4:0]  rd_b_idx = '0;
  logic [31:0] rd_b_data;

  logic [31:0] model [32];
  int checks = 0;
  int failures = 0;

  regbank u_regbank (
    .clk(clk), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Drives a write in the high phase, lets the falling edge take it, then drops enable.
  task automatic do_write(input logic [4:0] idx, input logic [31:0] data);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_idx = idx; wr_data = data;
    @(negedge clk); #1;
    wr_en = 1'b0;
    if (idx != 0) model[idx] = data;
  endtask

  task automatic read_both(input string req, input logic [4:0] a, input logic [4:0] b);
    rd_a_idx = a; rd_b_idx = b; #1;
    chk(req, rd_a_data, model[a]);
    chk(req, rd_b_data, model[b]);
  endtask

  task automatic t_reset();
    @(posedge clk); #1; clr = 1'b1;
    @(posedge clk); #1; clr = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    for (int i = 0; i < 32; i++) read_both("R5 reset", 5'(i), 5'(31 - i));
  endtask

  task automatic t_fill();
    for (int i = 1; i < 32; i++) do_write(5'(i), 32'h8000_0001 ^ (32'(i) * 32'h0101_0A3B));
    for (int i = 0; i < 32; i++) read_both("R1 R3 fill", 5'(i), 5'((i + 7) % 32));
  endtask

  task automatic t_comb_read();
    @(posedge clk); #2;
    rd_a_idx = 5'd3; #1;
    chk("R2 comb", rd_a_data, model[3]);
    rd_a_idx = 5'd30; #1;
    chk("R2 comb", rd_a_data, model[30]);
  endtask

  task automatic t_zero_slot();
    do_write(5'd0, 32'hFFFF_FFFF);
    read_both("R4 zero", 5'd0, 5'd0);
    read_both("R4 neighbour", 5'd1, 5'd0);
  endtask

  task automatic t_no_enable();
    @(posedge clk); #1;
    wr_en = 1'b0; wr_idx = 5'd9; wr_data = 32'hDEAD_BEEF;
    @(negedge clk); #1;
    read_both("R8 idle", 5'd9, 5'd9);
  endtask

  task automatic t_old_new();
    logic [31:0] old_v;
    old_v = model[17];
    @(posedge clk); #1;
    rd_a_idx = 5'd17; rd_b_idx = 5'd17;
    wr_en = 1'b1; wr_idx = 5'd17; wr_data = 32'h1234_5678;
    #2;
    chk("R7 old", rd_a_data, old_v);
    @(negedge clk); #1;
    wr_en = 1'b0;
    model[17] = 32'h1234_5678;
    chk("R7 new", rd_a_data, 32'h1234_5678);
    chk("R6 same", rd_b_data, 32'h1234_5678);
  endtask

  task automatic t_clear_priority();
    @(posedge clk); #1;
    clr = 1'b1; wr_en = 1'b1; wr_idx = 5'd5; wr_data = 32'hA5A5_A5A5;
    @(negedge clk); #1;
    for (int i = 0; i < 32; i++) model[i] = '0;
    read_both("R5 priority", 5'd5, 5'd31);
    @(posedge clk); #1;
    clr = 1'b0; wr_en = 1'b0;
    read_both("R5 priority after", 5'd5, 5'd12);
  endtask

  task automatic t_async_clear();
    do_write(5'd21, 32'h0F0F_0F0F);
    @(posedge clk); #1;
    rd_a_idx = 5'd21; #1;
    chk("R5 before", rd_a_data, 32'h0F0F_0F0F);
    clr = 1'b1; #1;
    chk("R5 async", rd_a_data, 32'h0);
    clr = 1'b0; #1;
    model[21] = '0;
    chk("R5 released", rd_a_data, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    t_reset();
    t_fill();
    t_comb_read();
    t_zero_slot();
    t_no_enable();
    t_old_new();
    t_clear_priority();
    t_fill();
    t_async_clear();
    summary();
  end
endmodule